// File: doc/BRIEF.md
# Priority-Table Interrupt Winner Resolver

This block picks, for each of two interrupt groups, the single active source that a software-programmed priority table ranks highest. It receives the already-masked activity vector of all sources (one bit per source, set when the source is both pending and enabled), a steering vector that assigns each source to the fast group (bit set) or to the normal group (bit clear), and a table of priority slots. Each slot names one source. Slot 0 is the most urgent and the last slot the least. The table alone fixes the priority. The source numbering has no part in it.

Both groups are searched independently in the same cycle. The two results are packed into one 32-bit status word: the fast-group result in the lower half and the normal-group result in the upper half. The word is registered once. A read-back path or an interrupt-entry routine can sample it one cycle after the table or the activity changes. All pins are plain level signals sampled on every clock. There is no stream and no handshake, so nothing can stall the block and nothing can apply back-pressure to it. A new result appears on every cycle.

Top module: `irq_prio_resolver`

## Requirements
- R1: Each table slot is a 32-bit word in which bit 31 is the enable flag and bits 5:0 hold the source number. All other bits of the slot are ignored.
- R2: A slot takes part only when its enable flag is 1 and its source number is below the source count (40). Any other slot is skipped, even if that source is active.
- R3: Within a group, the winner is the taking-part slot with the lowest index whose source is active.
- R4: A source belongs to the fast group when its activity bit and its steering bit are both 1. It belongs to the normal group when its activity bit is 1 and its steering bit is 0.
- R5: When the fast group has no winner, status bits 15:0 read 0x003F. When the normal group has no winner, bits 31:16 read 0x003F. While reset is held, the whole word is 0x003F003F.
- R6: When the fast group has a winner, status bit 15 is 1 and bits 5:0 carry the winning source number.
- R7: When the normal group has a winner, status bit 31 is 1 and bits 21:16 carry the winning source number.
- R8: The two groups are resolved independently, so both halves can report a winner in the same word.
- R9: Status bits 30:22 and 14:6 are always 0.
- R10: The status word reflects the inputs sampled at the previous rising clock edge. It does not change between edges.
- R11: When several slots name the same source, the slot with the lowest index decides the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| act_i | input | 40 | Masked activity, one bit per source |
| steer_i | input | 40 | Group steering per source: 1 = fast, 0 = normal |
| table_i | input | 1280 | Priority slots, slot k at bits 32k+31 to 32k |
| status_o | output | 32 | Packed winner word (registered) |

## Verification
A wrong slot decode, such as a missed enable check or a range check that lets source numbers 40 to 63 through, shows up as a wrong source number or a false winner flag in the status word. It appears on the first cycle after the table or the activity exposes it. A wrong priority order only shows when two or more active slots compete, so the stimulus mixes dense and sparse activity with crowded tables. A fault in group steering or in half packing corrupts the opposite half or the reserved zero bits. This appears one cycle after the inputs change, and no history hides it, because the block keeps no state beyond the output register.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  // Slot word layout and packed-result layout (fixed by the status format)
  localparam int unsigned SLOT_W   = 32;
  localparam int unsigned EN_BIT   = 31;
  localparam int unsigned ID_W     = 6;
  localparam int unsigned HALF_W   = 16;
  localparam int unsigned ID_SPACE = 1 << ID_W;
  localparam logic [ID_W-1:0] NO_WINNER = '1;

  typedef struct packed {
    logic             found;
    logic [HALF_W-ID_W-2:0] zero;
    logic [ID_W-1:0]  id;
  } half_t;

  typedef struct packed {
    half_t normal;
    half_t fast;
  } status_t;
endpackage

// File: rtl/prio_slot_decode.sv
module prio_slot_decode
  import irq_prio_pkg::*;
#(
  parameter int unsigned NSRC  = 40,
  parameter int unsigned NSLOT = 40
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NSRC-1:0]               act_i,
  input  logic [NSRC-1:0]               steer_i,
  input  logic [NSLOT*SLOT_W-1:0]       table_i,
  output logic [NSLOT-1:0]              fast_hit_o,
  output logic [NSLOT-1:0]              norm_hit_o,
  output logic [NSLOT-1:0][ID_W-1:0]    id_o
);
  // Pad to the full ID space so every 6-bit index is in range
  logic [ID_SPACE-1:0] act_pad, steer_pad;
  assign act_pad   = ID_SPACE'(act_i);
  assign steer_pad = ID_SPACE'(steer_i);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [SLOT_W-1:0] word;
    logic [ID_W-1:0]   sid;
    logic              usable, live;

    assign word   = table_i[s*SLOT_W +: SLOT_W];
    assign sid    = word[ID_W-1:0];
    assign usable = word[EN_BIT] && (32'(sid) < NSRC);
    assign live   = usable && act_pad[sid];

    assign fast_hit_o[s] = live &&  steer_pad[sid];
    assign norm_hit_o[s] = live && !steer_pad[sid];
    assign id_o[s]       = sid;

    // A slot never counts for both groups at once
    assert_group_disjoint_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(fast_hit_o[s] && norm_hit_o[s]));
    // A hit always comes from an enabled slot naming a real source
    assert_skip_unusable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_hit_o[s] || norm_hit_o[s]) |-> (table_i[s*SLOT_W + EN_BIT] && 32'(id_o[s]) < NSRC));
  end
endmodule

// File: rtl/prio_first_pick.sv
module prio_first_pick
  import irq_prio_pkg::*;
#(
  parameter int unsigned NSLOT = 40
) (
  input  logic [NSLOT-1:0]           hit_i,
  input  logic [NSLOT-1:0][ID_W-1:0] id_i,
  output logic                       found_o,
  output logic [ID_W-1:0]            id_o
);
  // Scan from the back so the lowest hitting index is written last
  always_comb begin
    found_o = 1'b0;
    id_o    = NO_WINNER;
    for (int k = NSLOT - 1; k >= 0; k--) begin
      if (hit_i[k]) begin
        found_o = 1'b1;
        id_o    = id_i[k];
      end
    end
  end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_prio_pkg::*;
#(
  parameter int unsigned NSRC  = 40,
  parameter int unsigned NSLOT = 40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSRC-1:0]         act_i,
  input  logic [NSRC-1:0]         steer_i,
  input  logic [NSLOT*SLOT_W-1:0] table_i,
  output logic [31:0]             status_o
);
  localparam status_t IDLE_WORD = '{
    normal: '{found: 1'b0, zero: '0, id: NO_WINNER},
    fast:   '{found: 1'b0, zero: '0, id: NO_WINNER}};

  logic [NSLOT-1:0]           fast_hit, norm_hit;
  logic [NSLOT-1:0][ID_W-1:0] slot_id;
  logic                       fast_found, norm_found;
  logic [ID_W-1:0]            fast_id, norm_id;
  status_t                    word_d, word_q;

  prio_slot_decode #(.NSRC(NSRC), .NSLOT(NSLOT)) u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_i      (act_i),
    .steer_i    (steer_i),
    .table_i    (table_i),
    .fast_hit_o (fast_hit),
    .norm_hit_o (norm_hit),
    .id_o       (slot_id)
  );

  prio_first_pick #(.NSLOT(NSLOT)) u_pick_fast (
    .hit_i   (fast_hit),
    .id_i    (slot_id),
    .found_o (fast_found),
    .id_o    (fast_id)
  );

  prio_first_pick #(.NSLOT(NSLOT)) u_pick_norm (
    .hit_i   (norm_hit),
    .id_i    (slot_id),
    .found_o (norm_found),
    .id_o    (norm_id)
  );

  always_comb begin
    word_d             = IDLE_WORD;
    word_d.fast.found  = fast_found;
    word_d.fast.id     = fast_id;
    word_d.normal.found = norm_found;
    word_d.normal.id    = norm_id;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) word_q <= IDLE_WORD;
    else        word_q <= word_d;
  end

  assign status_o = word_q;

  // Marks that the output register has loaded at least one real result
  logic primed;
  always_ff @(posedge clk) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[30:22] == '0) && (status_o[14:6] == '0));
  assert_fast_idle_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[15] |-> (status_o[5:0] == 6'h3F));
  assert_norm_idle_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[31] |-> (status_o[21:16] == 6'h3F));
  assert_norm_id_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[31] |-> (32'(status_o[21:16]) < NSRC));
  assert_fast_id_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[15] |-> (32'(status_o[5:0]) < NSRC));
  assert_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $stable(act_i) && $stable(steer_i) && $stable(table_i)) |=> $stable(status_o));
endmodule

// File: tb/sim_irq_prio_resolver.sv
module sim_irq_prio_resolver;
  localparam int NSRC  = 40;
  localparam int NSLOT = 40;
  localparam int TW    = NSLOT * 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] act = '0;
  logic [NSRC-1:0] steer = '0;
  logic [TW-1:0]   tbl = '0;
  logic [31:0]     status;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  irq_prio_resolver #(.NSRC(NSRC), .NSLOT(NSLOT)) u0 (
    .clk(clk), .rst_n(rst_n), .act_i(act), .steer_i(steer),
    .table_i(tbl), .status_o(status)
  );

  function automatic logic [31:0] model(logic [NSRC-1:0] a, logic [NSRC-1:0] s,
                                        logic [TW-1:0] t);
    logic [15:0] lo, hi;
    bit got_f, got_n;
    lo = 16'h003F; hi = 16'h003F; got_f = 0; got_n = 0;
    for (int k = 0; k < NSLOT; k++) begin
      logic [31:0] e;
      int id;
      e  = t[k*32 +: 32];
      id = int'(e[5:0]);
      if (e[31] && id < NSRC && a[id]) begin
        if (s[id] && !got_f) begin got_f = 1; lo = 16'h8000 | 16'(id); end
        if (!s[id] && !got_n) begin got_n = 1; hi = 16'h8000 | 16'(id); end
      end
    end
    return {hi, lo};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic put_slot(int k, logic [31:0] v);
    tbl[k*32 +: 32] = v;
  endtask

  // Drive at a falling edge, check after the next rising edge
  task automatic apply(string req, logic [NSRC-1:0] a, logic [NSRC-1:0] s);
    logic [31:0] prev;
    @(negedge clk);
    prev  = status;
    act   = a;
    steer = s;
    #1 check({req, " R10 hold"}, status, prev);
    @(posedge clk);
    @(negedge clk);
    check(req, status, model(act, steer, tbl));
    check("R9 reserved", status & 32'h7FC0_7FC0, 32'h0);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R5 reset word", status, 32'h003F_003F);
    rst_n = 1'b1;

    // R5: populated table, nothing active
    for (int k = 0; k < NSLOT; k++) put_slot(k, 32'h8000_0000 | k);
    apply("R5 idle", '0, '0);
    check("R5 idle const", status, 32'h003F_003F);

    // R3/R7: slot0 -> src7, slot1 -> src3, both active, normal group
    tbl = '0;
    put_slot(0, 32'h8000_0007);
    put_slot(1, 32'h8000_0003);
    apply("R3 order", (40'd1 << 7) | (40'd1 << 3), '0);
    check("R7 normal winner", status, 32'h8007_003F);

    // R4/R6/R8: steer src7 fast -> both halves win
    apply("R8 both", (40'd1 << 7) | (40'd1 << 3), 40'd1 << 7);
    check("R6 fast winner", status, 32'h8003_8007);

    // R2: slot0 enable clear -> skipped
    put_slot(0, 32'h0000_0007);
    apply("R2 disabled", (40'd1 << 7) | (40'd1 << 3), 40'd1 << 7);
    check("R2 disabled const", status, 32'h8003_003F);

    // R2: enabled slot with id 45 is skipped; R1: junk bits in 30:6 ignored
    tbl = '0;
    put_slot(0, 32'h8000_002D);
    put_slot(1, 32'hFFFF_FFC5);
    apply("R1 R2 range", {NSRC{1'b1}}, '0);
    check("R1 junk bits", status, 32'h8005_003F);

    // R11: duplicate source in slots 0 and 1
    tbl = '0;
    put_slot(0, 32'h8000_000C);
    put_slot(1, 32'h8000_000C);
    put_slot(2, 32'h8000_0001);
    apply("R11 duplicate", (40'd1 << 12) | 40'd2, 40'd1 << 12);
    check("R11 const", status, 32'h8001_800C);

    // R3: only last slot, highest source
    tbl = '0;
    put_slot(NSLOT-1, 32'h8000_0027);
    apply("R3 last slot", 40'd1 << 39, '0);
    check("R3 last const", status, 32'h8027_003F);

    // Random mix: R1 R2 R3 R4 R8 R11
    for (int it = 0; it < 400; it++) begin
      logic [NSRC-1:0] a, s;
      for (int k = 0; k < NSLOT; k++) begin
        logic [31:0] e;
        e = $urandom;
        e[31] = ($urandom % 4) != 0;
        e[5:0] = (($urandom % 8) == 0) ? 6'(40 + $urandom % 24) : 6'($urandom % 40);
        put_slot(k, e);
      end
      a = {$urandom, $urandom};
      if (it % 3 == 1) a = a & {$urandom, $urandom} & {$urandom, $urandom};
      if (it % 5 == 2) a = '0;
      s = {$urandom, $urandom};
      apply("R3 R4 random", a, s);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule